// File: doc/BRIEF.md
# Debug Abstract Register-Access Sequencer

This block sits inside a debug module and turns a register-access command from the debug host into a short run of 32-bit RISC-V instruction words. It writes those words, one per clock cycle, into the small abstract-program area that a halted hart fetches from, and then raises the "go" bit of the selected hart in the per-hart flag region. The hart runs the words on its own; this block only produces them and starts the hart.

The register number picks the kind of access. Integer and floating-point registers each take one load or store against the shared data slot at address 0x380, with x0 as the base register. A CSR is reached through s0: s0 is saved to the debug scratch CSR, the value moves between the data slot and the CSR through s0, and s0 is then restored. The CSR path is only built in hardware when the general program buffer is too small to hold the host's own code. Every sequence ends with either a breakpoint or, when post-execution is asked for, a forward jump that lands on the first word of the program buffer, which sits right after the five-word abstract area.

The control is a three-state machine. IDLE waits for a command and takes the IDLE to EMIT transition when a supported command arrives with no error pending. EMIT writes one word per cycle and stays in EMIT until the word at the final index has been written, then takes EMIT to LAUNCH. LAUNCH writes the go flag for one cycle and returns to IDLE.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset `busy` is 0, `cmd_err` is 0 (none), and neither `buf_we` nor `flag_we` is asserted.
- R2: With transfer set and regno in 0x1000..0x101F, word 0 is, for integer register regno-0x1000, a load (lw for size 2, ld for size 3) on a write command or a store (sw or sd) on a read command, always with base x0 and offset 0x380; the ending word follows at index 1.
- R3: With transfer set and regno in 0x1020..0x103F, word 0 is, for FP register regno-0x1020, flw/fld on a write or fsw/fsd on a read (size 2 or 3), base x0 and offset 0x380; the ending word follows at index 1.
- R4: With transfer set, regno below 0x1000 and `progbuf_words` below 2, words 0..3 are: csrrw x0,0x7B2,x8; then (write) a load of x8 from 0x380 followed by csrrw x0,regno,x8, or (read) csrrs x8,regno,x0 followed by a store of x8 to 0x380; then csrrs x8,0x7B2,x0. The ending word is at index 4.
- R5: A size other than 2 or 3 on any transfer path, a CSR regno while `progbuf_words` is 2 or more, or a regno of 0x1040 or above sets `cmd_err` to 2 (not supported) and launches nothing: no buffer write, no flag write, `busy` stays 0.
- R6: The ending word at index i is ebreak (0x00100073) when postexec is 0, and jal x0 with byte offset 20-4*i when postexec is 1 (for example 0x0100006F at index 1, 0x0040006F at index 4).
- R7: With transfer clear, only the ending word is written, at index 0 (0x0140006F with postexec, else ebreak), whatever regno and size hold.
- R8: Words are written one per cycle with `buf_idx` counting up from 0, starting the cycle after the command is taken; in the cycle after the last word, `flag_we` is 1 for one cycle with `flag_addr` = 0x400 + hart index and `flag_set` = 0x01 (bit 0 is go).
- R9: `busy` is 1 from the cycle after the command is taken through the flag-write cycle; a command presented while `busy` is 1 sets `cmd_err` to 1 (busy) and does not disturb the running sequence.
- R10: A nonzero `cmd_err` holds until `err_clear` is pulsed; while it is nonzero, commands are ignored and nothing is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_transfer | input | 1 | Command moves data between register and data slot |
| cmd_write | input | 1 | 1: data slot to register; 0: register to data slot |
| cmd_postexec | input | 1 | End with a jump into the program buffer instead of ebreak |
| cmd_size | input | 3 | Access size code (2 = 32-bit, 3 = 64-bit) |
| cmd_regno | input | 16 | Register number |
| progbuf_words | input | 5 | Number of words in the general program buffer |
| hart_sel | input | 4 | Selected hart index |
| err_clear | input | 1 | Clears the command error |
| buf_we | output | 1 | Abstract-area word write strobe |
| buf_idx | output | 3 | Word index within the abstract area |
| buf_wdata | output | 32 | Instruction word |
| flag_we | output | 1 | Flag-byte write strobe |
| flag_addr | output | 12 | Byte address of the selected hart's flag |
| flag_set | output | 8 | Bits to set in that flag byte |
| busy | output | 1 | A sequence is being written |
| cmd_err | output | 3 | 0 none, 1 busy, 2 not supported |

## Verification
On every cycle the assertions check the write ordering: the index starts at 0 and steps by one, the go flag comes only right after the last word, nothing is written while idle, a second command during a sequence flags the busy error, and the error code neither changes without a clear nor lets a sequence start. The exact instruction encodings for each register range, size and direction, the jump offsets, the flag address for each hart, and the rejection of every unsupported case can only be shown by the bench's scenarios, which compare each written word against a queue of expected words.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    typedef enum logic [1:0] {
        PATH_NONE = 2'd0,
        PATH_GPR  = 2'd1,
        PATH_FPR  = 2'd2,
        PATH_CSR  = 2'd3
    } path_e;

    typedef struct packed {
        path_e       path;
        logic        wr;      // 1: data slot -> register
        logic        dbl;     // 64-bit access
        logic        post;    // end with jump into program buffer
        logic [11:0] reg_id;  // register index or CSR number
    } plan_t;

    localparam logic [2:0] ERR_NONE   = 3'd0;
    localparam logic [2:0] ERR_BUSY   = 3'd1;
    localparam logic [2:0] ERR_NOTSUP = 3'd2;

    localparam logic [6:0] OPC_LOAD     = 7'h03;
    localparam logic [6:0] OPC_LOAD_FP  = 7'h07;
    localparam logic [6:0] OPC_STORE    = 7'h23;
    localparam logic [6:0] OPC_STORE_FP = 7'h27;
    localparam logic [6:0] OPC_JAL      = 7'h6F;
    localparam logic [6:0] OPC_SYSTEM   = 7'h73;

    localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;
    localparam logic [4:0]  REG_S0      = 5'd8;

    // load (to_reg) or store against x0 + off
    function automatic logic [31:0] enc_xfer(input logic fp, input logic to_reg,
                                             input logic dbl, input logic [4:0] r,
                                             input logic [11:0] off);
        logic [2:0] f3;
        f3 = {2'b01, dbl};
        if (to_reg)
            enc_xfer = {off, 5'd0, f3, r, (fp ? OPC_LOAD_FP : OPC_LOAD)};
        else
            enc_xfer = {off[11:5], r, 5'd0, f3, off[4:0], (fp ? OPC_STORE_FP : OPC_STORE)};
    endfunction

    // csrrw x0, csr, rs1
    function automatic logic [31:0] enc_csr_put(input logic [11:0] csr, input logic [4:0] rs1);
        enc_csr_put = {csr, rs1, 3'b001, 5'd0, OPC_SYSTEM};
    endfunction

    // csrrs rd, csr, x0
    function automatic logic [31:0] enc_csr_get(input logic [11:0] csr, input logic [4:0] rd);
        enc_csr_get = {csr, 5'd0, 3'b010, rd, OPC_SYSTEM};
    endfunction

    // jal x0, off
    function automatic logic [31:0] enc_jump(input logic [20:0] off);
        enc_jump = {off[20], off[10:1], off[11], off[19:12], 5'd0, OPC_JAL};
    endfunction

endpackage

// File: rtl/dcs_decode.sv
module dcs_decode
    import dcs_pkg::*;
#(
    parameter int RN_W   = 16,
    parameter int PB_W   = 5,
    parameter int IDX_W  = 3,
    parameter int CSR_SEQ_LAST = 4
) (
    input  logic              transfer,
    input  logic              write,
    input  logic              postexec,
    input  logic [2:0]        size,
    input  logic [RN_W-1:0]   regno,
    input  logic [PB_W-1:0]   pb_words,
    output plan_t             plan,
    output logic [IDX_W-1:0]  last_idx,
    output logic              notsup
);
    localparam logic [RN_W-1:0] GPR_BASE = RN_W'(16'h1000);
    localparam logic [RN_W-1:0] FPR_BASE = RN_W'(16'h1020);
    localparam logic [RN_W-1:0] FPR_END  = RN_W'(16'h1040);

    logic size_ok;
    assign size_ok = (size == 3'd2) || (size == 3'd3);

    always_comb begin
        plan.path   = PATH_NONE;
        plan.wr     = write;
        plan.dbl    = (size == 3'd3);
        plan.post   = postexec;
        plan.reg_id = 12'(regno);
        last_idx    = '0;
        notsup      = 1'b0;
        if (transfer) begin
            if (regno < GPR_BASE) begin
                plan.path = PATH_CSR;
                last_idx  = IDX_W'(CSR_SEQ_LAST);
                notsup    = !size_ok || (pb_words >= PB_W'(2));
            end else if (regno < FPR_BASE) begin
                plan.path   = PATH_GPR;
                plan.reg_id = {7'd0, regno[4:0]};
                last_idx    = IDX_W'(1);
                notsup      = !size_ok;
            end else if (regno < FPR_END) begin
                plan.path   = PATH_FPR;
                plan.reg_id = {7'd0, regno[4:0]};
                last_idx    = IDX_W'(1);
                notsup      = !size_ok;
            end else begin
                notsup = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dcs_wordgen.sv
module dcs_wordgen
    import dcs_pkg::*;
#(
    parameter int          IDX_W     = 3,
    parameter int          ABS_WORDS = 5,
    parameter logic [11:0] DATA_OFF  = 12'h380,
    parameter logic [11:0] SCR_CSR   = 12'h7B2
) (
    input  plan_t             plan,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [31:0]       word
);
    logic [20:0] jump_off;
    logic [31:0] tail_word;
    logic [31:0] one_xfer;
    logic        is_fp;

    // distance from word idx to the first program-buffer word
    assign jump_off  = (21'(ABS_WORDS) - 21'(idx)) << 2;
    assign tail_word = plan.post ? enc_jump(jump_off) : WORD_EBREAK;
    assign is_fp     = (plan.path == PATH_FPR);
    assign one_xfer  = enc_xfer(is_fp, plan.wr, plan.dbl, plan.reg_id[4:0], DATA_OFF);

    always_comb begin
        word = tail_word;
        if (idx != last_idx) begin
            unique case (plan.path)
                PATH_GPR, PATH_FPR: word = one_xfer;
                PATH_CSR: begin
                    unique case (idx)
                        IDX_W'(0): word = enc_csr_put(SCR_CSR, REG_S0);
                        IDX_W'(1): word = plan.wr ? enc_xfer(1'b0, 1'b1, plan.dbl, REG_S0, DATA_OFF)
                                                  : enc_csr_get(plan.reg_id, REG_S0);
                        IDX_W'(2): word = plan.wr ? enc_csr_put(plan.reg_id, REG_S0)
                                                  : enc_xfer(1'b0, 1'b0, plan.dbl, REG_S0, DATA_OFF);
                        IDX_W'(3): word = enc_csr_get(SCR_CSR, REG_S0);
                        default:   word = tail_word;
                    endcase
                end
                default: word = tail_word;
            endcase
        end
    end
endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
    import dcs_pkg::*;
#(
    parameter int          IDX_W     = 3,
    parameter int          HART_W    = 4,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] FLAG_BASE = 12'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              notsup,
    input  plan_t             plan_in,
    input  logic [IDX_W-1:0]  last_in,
    input  logic [HART_W-1:0] hart_in,
    input  logic              err_clear,
    output plan_t             plan_q,
    output logic [IDX_W-1:0]  last_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic              buf_we,
    output logic              flag_we,
    output logic [ADDR_W-1:0] flag_addr,
    output logic              busy,
    output logic [2:0]        err_q
);
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_EMIT   = 2'd1,
        S_LAUNCH = 2'd2
    } state_e;

    state_e            state_q, state_d;
    logic [HART_W-1:0] hart_q;
    logic              accept, collide, reject;

    assign accept  = (state_q == S_IDLE) && cmd_valid && (err_q == ERR_NONE) && !notsup;
    assign reject  = (state_q == S_IDLE) && cmd_valid && (err_q == ERR_NONE) && notsup;
    assign collide = (state_q != S_IDLE) && cmd_valid && (err_q == ERR_NONE);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_EMIT;
            S_EMIT:   if (idx_q == last_q) state_d = S_LAUNCH;
            S_LAUNCH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and captured command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            plan_q  <= '0;
            last_q  <= '0;
            idx_q   <= '0;
            hart_q  <= '0;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            if (accept) begin
                plan_q <= plan_in;
                last_q <= last_in;
                hart_q <= hart_in;
                idx_q  <= '0;
            end else if (state_q == S_EMIT && idx_q != last_q) begin
                idx_q <= idx_q + IDX_W'(1);
            end
            if (collide)        err_q <= ERR_BUSY;
            else if (reject)    err_q <= ERR_NOTSUP;
            else if (err_clear) err_q <= ERR_NONE;
        end
    end

    // outputs
    always_comb begin
        buf_we    = 1'b0;
        flag_we   = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            S_IDLE:   ;
            S_EMIT:   begin buf_we  = 1'b1; busy = 1'b1; end
            S_LAUNCH: begin flag_we = 1'b1; busy = 1'b1; end
            default:  ;
        endcase
        flag_addr = FLAG_BASE[ADDR_W-1:0] + ADDR_W'(hart_q);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!buf_we && !flag_we)); // R9
    AST_IDX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_we) |-> (idx_q == '0)); // R8
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && $past(buf_we)) |-> (idx_q == $past(idx_q) + IDX_W'(1))); // R8
    AST_GO_AFTER_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> ($past(buf_we) && !buf_we)); // R8
    AST_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid && err_q == ERR_NONE) |=> (err_q == ERR_BUSY)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != ERR_NONE && !err_clear) |=> $stable(err_q)); // R10
    AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(err_q) == ERR_NONE)); // R10
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dcs_pkg::*;
#(
    parameter int          RN_W      = 16,
    parameter int          PB_W      = 5,
    parameter int          HART_W    = 4,
    parameter int          ADDR_W    = 12,
    parameter int          ABS_WORDS = 5,
    parameter logic [11:0] DATA_OFF  = 12'h380,
    parameter logic [11:0] FLAG_BASE = 12'h400,
    parameter logic [11:0] SCR_CSR   = 12'h7B2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_transfer,
    input  logic              cmd_write,
    input  logic              cmd_postexec,
    input  logic [2:0]        cmd_size,
    input  logic [RN_W-1:0]   cmd_regno,
    input  logic [PB_W-1:0]   progbuf_words,
    input  logic [HART_W-1:0] hart_sel,
    input  logic              err_clear,
    output logic              buf_we,
    output logic [2:0]        buf_idx,
    output logic [31:0]       buf_wdata,
    output logic              flag_we,
    output logic [ADDR_W-1:0] flag_addr,
    output logic [7:0]        flag_set,
    output logic              busy,
    output logic [2:0]        cmd_err
);
    localparam int IDX_W = $clog2(ABS_WORDS);

    plan_t            dec_plan, run_plan;
    logic [IDX_W-1:0] dec_last, run_last, run_idx;
    logic             dec_notsup;

    dcs_decode #(
        .RN_W(RN_W), .PB_W(PB_W), .IDX_W(IDX_W), .CSR_SEQ_LAST(ABS_WORDS - 1)
    ) u_decode (
        .transfer (cmd_transfer),
        .write    (cmd_write),
        .postexec (cmd_postexec),
        .size     (cmd_size),
        .regno    (cmd_regno),
        .pb_words (progbuf_words),
        .plan     (dec_plan),
        .last_idx (dec_last),
        .notsup   (dec_notsup)
    );

    dcs_ctrl #(
        .IDX_W(IDX_W), .HART_W(HART_W), .ADDR_W(ADDR_W), .FLAG_BASE(FLAG_BASE)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .notsup    (dec_notsup),
        .plan_in   (dec_plan),
        .last_in   (dec_last),
        .hart_in   (hart_sel),
        .err_clear (err_clear),
        .plan_q    (run_plan),
        .last_q    (run_last),
        .idx_q     (run_idx),
        .buf_we    (buf_we),
        .flag_we   (flag_we),
        .flag_addr (flag_addr),
        .busy      (busy),
        .err_q     (cmd_err)
    );

    dcs_wordgen #(
        .IDX_W(IDX_W), .ABS_WORDS(ABS_WORDS), .DATA_OFF(DATA_OFF), .SCR_CSR(SCR_CSR)
    ) u_wordgen (
        .plan     (run_plan),
        .idx      (run_idx),
        .last_idx (run_last),
        .word     (buf_wdata)
    );

    assign buf_idx  = 3'(run_idx);
    assign flag_set = 8'h01;

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && dec_notsup) |=> (!busy && !buf_we && !flag_we)); // R5
endmodule

// File: tb/dbg_cmd_seq_bench.sv
`timescale 1ns/1ps
module dbg_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_transfer = 1'b0, cmd_write = 1'b0, cmd_postexec = 1'b0;
    logic [2:0]  cmd_size = 3'd0;
    logic [15:0] cmd_regno = 16'd0;
    logic [4:0]  progbuf_words = 5'd0;
    logic [3:0]  hart_sel = 4'd0;
    logic        err_clear = 1'b0;
    logic        buf_we, flag_we, busy;
    logic [2:0]  buf_idx, cmd_err;
    logic [31:0] buf_wdata;
    logic [11:0] flag_addr;
    logic [7:0]  flag_set;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [35:0] exp_q[$];   // {is_flag, idx[2:0], data[31:0]}
    string       tag_q[$];

    always #4 clk = ~clk;

    dbg_cmd_seq u_dbg_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_transfer(cmd_transfer),
        .cmd_write(cmd_write), .cmd_postexec(cmd_postexec), .cmd_size(cmd_size),
        .cmd_regno(cmd_regno), .progbuf_words(progbuf_words), .hart_sel(hart_sel),
        .err_clear(err_clear), .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .flag_we(flag_we), .flag_addr(flag_addr), .flag_set(flag_set), .busy(busy),
        .cmd_err(cmd_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // expected-word encoders, written from the requirement text
    function automatic logic [31:0] w_mem(input bit fp, input bit ld, input bit dbl, input int r);
        logic [2:0] f3 = dbl ? 3'd3 : 3'd2;
        logic [4:0] rr = 5'(r);
        if (ld) return {12'h380, 5'd0, f3, rr, (fp ? 7'h07 : 7'h03)};
        return {7'h1C, rr, 5'd0, f3, 5'd0, (fp ? 7'h27 : 7'h23)};
    endfunction
    function automatic logic [31:0] w_csrw(input logic [11:0] c);
        return {c, 5'd8, 3'b001, 5'd0, 7'h73};
    endfunction
    function automatic logic [31:0] w_csrr(input logic [11:0] c);
        return {c, 5'd0, 3'b010, 5'd8, 7'h73};
    endfunction
    function automatic logic [31:0] w_tail(input bit post, input int i);
        logic [10:0] off = 11'(20 - 4 * i);
        if (!post) return 32'h0010_0073;
        return {1'b0, off[10:1], 1'b0, 8'd0, 5'd0, 7'h6F};
    endfunction

    task automatic push_word(input int i, input logic [31:0] w, input string tag);
        exp_q.push_back({1'b0, 3'(i), w});
        tag_q.push_back(tag);
    endtask
    task automatic push_flag(input int hart, input string tag);
        exp_q.push_back({1'b1, 3'd0, 20'd0, 12'h400 + 12'(hart)});
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (buf_we || flag_we)) begin
            if (exp_q.size() == 0) begin
                chk(0, "R5/R10", "unexpected write", {flag_we, buf_idx, buf_wdata}, 36'd0);
            end else begin
                logic [35:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (e[35]) begin
                    chk(flag_we && !buf_we && flag_addr == e[11:0] && flag_set == 8'h01,
                        {t, "/R8"}, "go flag", {flag_we, 3'd0, 12'd0, flag_set, flag_addr},
                        {1'b1, 3'd0, 12'd0, 8'h01, e[11:0]});
                end else begin
                    chk(buf_we && !flag_we && buf_idx == e[34:32] && buf_wdata == e[31:0],
                        t, "buffer word", {flag_we, buf_idx, buf_wdata}, e);
                end
            end
        end
    end

    task automatic drive(input bit tr, input bit wr, input bit post, input logic [2:0] sz,
                         input logic [15:0] rn, input logic [4:0] pb, input logic [3:0] h);
        @(negedge clk);
        cmd_transfer = tr; cmd_write = wr; cmd_postexec = post; cmd_size = sz;
        cmd_regno = rn; progbuf_words = pb; hart_sel = h; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        for (int k = 0; k < 40 && (busy || exp_q.size() != 0); k++) @(negedge clk);
        chk(exp_q.size() == 0 && !busy, tag, "sequence finished", 36'(exp_q.size()), 36'd0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic clear_err;
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
    endtask

    task automatic expect_reject(input string tag);
        repeat (2) @(negedge clk);
        chk(cmd_err == 3'd2, tag, "err code notsup", 36'(cmd_err), 36'd2);
        chk(!busy, tag, "nothing launched", 36'(busy), 36'd0);
        clear_err();
        chk(cmd_err == 3'd0, "R10", "err cleared", 36'(cmd_err), 36'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && cmd_err == 0 && !buf_we && !flag_we, "R1", "reset state",
            {busy, cmd_err, buf_we, flag_we}, 36'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && cmd_err == 0, "R1", "idle after reset", {busy, cmd_err}, 36'd0);

        // R2 integer write, 32-bit, breakpoint ending
        push_word(0, w_mem(0, 1, 0, 10), "R2");
        push_word(1, w_tail(0, 1), "R6");
        push_flag(3, "R2");
        drive(1, 1, 0, 3'd2, 16'h100A, 5'd4, 4'd3);
        wait_done("R2");

        // R2 integer read, 64-bit, jump ending
        push_word(0, w_mem(0, 0, 1, 31), "R2");
        push_word(1, 32'h0100_006F, "R6");
        push_flag(0, "R2");
        drive(1, 0, 1, 3'd3, 16'h101F, 5'd8, 4'd0);
        wait_done("R2");

        // R3 FP write, 64-bit
        push_word(0, w_mem(1, 1, 1, 5), "R3");
        push_word(1, w_tail(0, 1), "R6");
        push_flag(15, "R3");
        drive(1, 1, 0, 3'd3, 16'h1025, 5'd0, 4'd15);
        wait_done("R3");

        // R3 FP read, 32-bit, jump
        push_word(0, w_mem(1, 0, 0, 31), "R3");
        push_word(1, w_tail(1, 1), "R6");
        push_flag(7, "R3");
        drive(1, 0, 1, 3'd2, 16'h103F, 5'd2, 4'd7);
        wait_done("R3");

        // R4 CSR write, 32-bit, progbuf 1
        push_word(0, w_csrw(12'h7B2), "R4");
        push_word(1, w_mem(0, 1, 0, 8), "R4");
        push_word(2, w_csrw(12'h300), "R4");
        push_word(3, w_csrr(12'h7B2), "R4");
        push_word(4, w_tail(0, 4), "R6");
        push_flag(2, "R4");
        drive(1, 1, 0, 3'd2, 16'h0300, 5'd1, 4'd2);
        wait_done("R4");

        // R4 CSR read, 64-bit, progbuf 0, jump offset 4
        push_word(0, w_csrw(12'h7B2), "R4");
        push_word(1, w_csrr(12'h7B0), "R4");
        push_word(2, w_mem(0, 0, 1, 8), "R4");
        push_word(3, w_csrr(12'h7B2), "R4");
        push_word(4, 32'h0040_006F, "R6");
        push_flag(1, "R4");
        drive(1, 0, 1, 3'd3, 16'h07B0, 5'd0, 4'd1);
        wait_done("R4");

        // R7 no transfer: only ending word at index 0
        push_word(0, 32'h0140_006F, "R7");
        push_flag(9, "R7");
        drive(0, 1, 1, 3'd7, 16'h5000, 5'd16, 4'd9);
        wait_done("R7");
        push_word(0, 32'h0010_0073, "R7");
        push_flag(4, "R7");
        drive(0, 0, 0, 3'd0, 16'hFFFF, 5'd0, 4'd4);
        wait_done("R7");

        // R5 unsupported cases
        drive(1, 1, 0, 3'd4, 16'h1003, 5'd0, 4'd0);
        expect_reject("R5");
        drive(1, 0, 0, 3'd2, 16'h0300, 5'd2, 4'd0);
        expect_reject("R5");
        drive(1, 0, 0, 3'd3, 16'h1040, 5'd0, 4'd0);
        expect_reject("R5");
        drive(1, 1, 0, 3'd1, 16'h0300, 5'd0, 4'd0);
        expect_reject("R5");

        // R9 collision while busy: running CSR sequence completes unchanged
        push_word(0, w_csrw(12'h7B2), "R9");
        push_word(1, w_csrr(12'h341), "R9");
        push_word(2, w_mem(0, 0, 0, 8), "R9");
        push_word(3, w_csrr(12'h7B2), "R9");
        push_word(4, w_tail(0, 4), "R9");
        push_flag(6, "R9");
        drive(1, 0, 0, 3'd2, 16'h0341, 5'd0, 4'd6);
        chk(busy, "R9", "busy after accept", 36'(busy), 36'd1);
        cmd_regno = 16'h1001; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_err == 3'd1, "R9", "busy error", 36'(cmd_err), 36'd1);
        wait_done("R9");

        // R10 sticky: error stays, command ignored
        drive(1, 1, 0, 3'd2, 16'h1002, 5'd0, 4'd0);
        repeat (3) @(negedge clk);
        chk(!busy, "R10", "ignored while error", 36'(busy), 36'd0);
        chk(cmd_err == 3'd1, "R10", "error held", 36'(cmd_err), 36'd1);
        clear_err();
        chk(cmd_err == 3'd0, "R10", "error cleared", 36'(cmd_err), 36'd0);
        push_word(0, w_mem(0, 1, 0, 2), "R10");
        push_word(1, w_tail(0, 1), "R10");
        push_flag(0, "R10");
        drive(1, 1, 0, 3'd2, 16'h1002, 5'd0, 4'd0);
        wait_done("R10");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule